// File: doc/BRIEF.md
# Fractional Clock Divider with Live Divisor Update

This block divides a source clock by a divisor that has an integer part and an 8-bit fractional part, counted in 1/256 steps. It produces a one-cycle clock-enable pulse at the start of every output period and a divided clock whose average period is the source period times the divisor. Periods are whole numbers of source cycles. A fractional accumulator makes some periods one cycle longer, so the long-term average comes out exactly right.

The divisor can be rewritten at any time through a data bus and a one-cycle write strobe, while the clock keeps running. A value written part-way through a period is held and loaded at the next period boundary, so no period is ever cut short. If the write lands in the last cycle of a period, the very next period already uses it. Only the low 16 bits of the integer field are used. When those bits are zero, the block divides by 65536. The reset divisor is exactly 1.0. At exactly 1.0 the output clock is the source clock itself.

Top module: `frac_clk_div`

## Requirements
- R1: After a synchronous reset the divisor is 1.0: `clk_en_o` is high in every cycle and `clk_o` follows `clk_i`.
- R2: For an integer divisor N ≥ 2 with zero fraction, `clk_en_o` pulses for one cycle once every N source cycles.
- R3: With integer part I and fraction F, any 256 consecutive output periods span exactly 256·I + F source cycles.
- R4: With a nonzero fraction, every period is either I or I+1 cycles long. With a zero fraction, every period is exactly I cycles.
- R5: An integer value whose low 16 bits are all zero divides by 65536, plus the fractional stretching.
- R6: Integer bits from bit 16 upward have no effect on the period length.
- R7: A write that arrives before the last cycle of a period leaves that period's length unchanged. The following period uses the new divisor.
- R8: A write in the last cycle of a period sets the length of the period that starts on the next cycle.
- R9: Outside the 1.0 case, `clk_o` is high for the first max(1, ⌊L/2⌋) cycles of each L-cycle period and low for the rest.
- R10: Integer 1 with a nonzero fraction F gives periods of 1 or 2 cycles, never shorter, averaging 1 + F/256.
- R11: Writing exactly 1.0 (integer low bits 1, fraction 0) returns the block to clock pass-through with an enable in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_i | input | 1 | Synchronous active-high reset |
| div_we_i | input | 1 | One-cycle strobe that captures a new divisor |
| div_int_i | input | 24 | Integer part of the divisor (only the low 16 bits are used) |
| div_frac_i | input | 8 | Fractional part of the divisor, in 1/256 units |
| clk_en_o | output | 1 | High in the first cycle of each output period |
| clk_o | output | 1 | Divided clock (the source clock itself at divisor 1.0) |

## Verification
Two things can happen in the same cycle: a divisor write and the period boundary that loads the next period's length. The bench steers a write into the last cycle of a 6-cycle period. It then checks that the period starting on the next edge already has the new 3-cycle length. A second directed case places a write in the middle of a 10-cycle period and checks that this period still runs its full ten cycles. Random divisors are written at random phases, and each is judged by the exact cycle total over 256 periods.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    typedef enum logic {
        MODE_DIVIDE = 1'b0,
        MODE_FOLLOW = 1'b1
    } out_mode_e;

    // Period base length for the used integer bits; zero selects 2^used_w.
    function automatic int unsigned eff_base(input int unsigned low, input int used_w);
        return (low == 0) ? (32'd1 << used_w) : low;
    endfunction

    // High phase of a divided period: floor(len/2), at least one cycle.
    function automatic int unsigned high_span(input int unsigned len);
        return ((len >> 1) == 0) ? 32'd1 : (len >> 1);
    endfunction

endpackage

// File: rtl/fd_hold.sv
module fd_hold #(
    parameter int USED_W = 16,
    parameter int FRAC_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              we_i,
    input  logic [USED_W-1:0] low_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [USED_W-1:0] nxt_low_o,
    output logic [FRAC_W-1:0] nxt_frac_o
);
    logic [USED_W-1:0] low_q;
    logic [FRAC_W-1:0] frac_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            low_q  <= USED_W'(1);
            frac_q <= '0;
        end else if (we_i) begin
            low_q  <= low_i;
            frac_q <= frac_i;
        end
    end

    // A write in the same cycle is forwarded so a boundary can use it at once.
    always_comb begin
        nxt_low_o  = we_i ? low_i  : low_q;
        nxt_frac_o = we_i ? frac_i : frac_q;
    end

    assert_hold_keep_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !we_i |=> ($stable(low_q) && $stable(frac_q)));

endmodule

// File: rtl/fd_accum.sv
module fd_accum #(
    parameter int FRAC_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              step_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              carry_o
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, frac_i};
        carry_o = sum[FRAC_W];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)       acc_q <= '0;
        else if (step_i) acc_q <= sum[FRAC_W-1:0];
    end

    assert_acc_idle_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !step_i |=> $stable(acc_q));

endmodule

// File: rtl/fd_period.sv
module fd_period
    import frac_div_pkg::*;
#(
    parameter int USED_W = 16,
    parameter int FRAC_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [USED_W-1:0] nxt_low_i,
    input  logic [FRAC_W-1:0] nxt_frac_i,
    input  logic              carry_i,
    output logic              bound_o,
    output logic              en_o,
    output logic              lvl_o,
    output out_mode_e         mode_o
);
    localparam int LEN_W = USED_W + 1;

    logic [LEN_W-1:0] cnt_q, len_q, hi_q, base_q;
    logic [LEN_W-1:0] cnt_d, len_d, hi_d, base_d;
    logic [LEN_W-1:0] base_n, len_n, hi_n;
    out_mode_e        mode_q, mode_d, mode_n;
    logic             en_q, lvl_q;

    always_comb begin
        base_n  = LEN_W'(eff_base(32'(nxt_low_i), USED_W));
        len_n   = base_n + LEN_W'(carry_i);
        hi_n    = LEN_W'(high_span(32'(len_n)));
        mode_n  = (nxt_low_i == USED_W'(1) && nxt_frac_i == '0) ? MODE_FOLLOW : MODE_DIVIDE;
        bound_o = (cnt_q == len_q - LEN_W'(1));
        if (bound_o) begin
            cnt_d  = '0;
            len_d  = len_n;
            hi_d   = hi_n;
            base_d = base_n;
            mode_d = mode_n;
        end else begin
            cnt_d  = cnt_q + LEN_W'(1);
            len_d  = len_q;
            hi_d   = hi_q;
            base_d = base_q;
            mode_d = mode_q;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q  <= '0;
            len_q  <= LEN_W'(1);
            hi_q   <= LEN_W'(1);
            base_q <= LEN_W'(1);
            mode_q <= MODE_FOLLOW;
            en_q   <= 1'b1;
            lvl_q  <= 1'b1;
        end else begin
            cnt_q  <= cnt_d;
            len_q  <= len_d;
            hi_q   <= hi_d;
            base_q <= base_d;
            mode_q <= mode_d;
            en_q   <= (cnt_d == '0);
            lvl_q  <= (cnt_d < hi_d);
        end
    end

    assign en_o   = en_q;
    assign lvl_o  = lvl_q;
    assign mode_o = mode_q;

    assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q < len_q);
    assert_bound_starts_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        bound_o |=> en_q);
    assert_len_bounds_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (len_q == base_q) || (len_q == base_q + LEN_W'(1)));
    assert_no_short_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !bound_o |=> $stable(len_q));
    assert_start_high_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        en_q |-> lvl_q);
    assert_end_low_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (bound_o && len_q > LEN_W'(1)) |-> !lvl_q);
    assert_follow_unit_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_q == MODE_FOLLOW) |-> (len_q == LEN_W'(1)));

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import frac_div_pkg::*;
#(
    parameter int INT_W  = 24,
    parameter int USED_W = 16,
    parameter int FRAC_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              div_we_i,
    input  logic [INT_W-1:0]  div_int_i,
    input  logic [FRAC_W-1:0] div_frac_i,
    output logic              clk_en_o,
    output logic              clk_o
);
    logic [USED_W-1:0] nxt_low;
    logic [FRAC_W-1:0] nxt_frac;
    logic              bound, carry, lvl;
    out_mode_e         mode;

    generate
        if (INT_W > USED_W) begin : g_drop_high
            logic unused_high;
            assign unused_high = ^div_int_i[INT_W-1:USED_W];
        end
    endgenerate

    fd_hold #(.USED_W(USED_W), .FRAC_W(FRAC_W)) u_hold (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .we_i       (div_we_i),
        .low_i      (div_int_i[USED_W-1:0]),
        .frac_i     (div_frac_i),
        .nxt_low_o  (nxt_low),
        .nxt_frac_o (nxt_frac)
    );

    fd_accum #(.FRAC_W(FRAC_W)) u_accum (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .step_i  (bound),
        .frac_i  (nxt_frac),
        .carry_o (carry)
    );

    fd_period #(.USED_W(USED_W), .FRAC_W(FRAC_W)) u_period (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .nxt_low_i  (nxt_low),
        .nxt_frac_i (nxt_frac),
        .carry_i    (carry),
        .bound_o    (bound),
        .en_o       (clk_en_o),
        .lvl_o      (lvl),
        .mode_o     (mode)
    );

    assign clk_o = (mode == MODE_FOLLOW) ? clk_i : lvl;

endmodule

// File: tb/frac_clk_div_test.sv
module frac_clk_div_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        we;
    logic [23:0] dint;
    logic [7:0]  dfrac;
    logic        en, clk_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    frac_clk_div uut (
        .clk_i(clk), .rst_i(rst), .div_we_i(we), .div_int_i(dint),
        .div_frac_i(dfrac), .clk_en_o(en), .clk_o(clk_out)
    );

    function automatic longint base_of(input logic [23:0] iv);
        return (iv[15:0] == 16'd0) ? 64'd65536 : longint'(iv[15:0]);
    endfunction

    function automatic longint total_of(input logic [23:0] iv, input logic [7:0] fv, input int n);
        return longint'(n) * base_of(iv) + ((n == 256) ? longint'(fv) : 64'd0);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Write a divisor at a negedge, then wait until the first period using it starts.
    task automatic set_div(input logic [23:0] iv, input logic [7:0] fv);
        we = 1'b1; dint = iv; dfrac = fv;
        @(negedge clk);
        we = 1'b0;
        while (!en) @(negedge clk);
    endtask

    // Starting at a negedge with en high, run n periods.
    task automatic collect(input int n, input bit chk_hi, output longint total,
                           output longint mn, output longint mx, output int hi_bad);
        total = 0; mn = 64'h7fffffff; mx = 0; hi_bad = 0;
        for (int p = 0; p < n; p++) begin
            longint len = 0;
            longint hcnt = 0;
            bit low_seen = 0;
            bit broken = 0;
            do begin
                if (clk_out) begin
                    if (low_seen) broken = 1;
                    hcnt++;
                end else low_seen = 1;
                len++;
                @(negedge clk);
            end while (!en);
            total += len;
            if (len < mn) mn = len;
            if (len > mx) mx = len;
            if (chk_hi && (broken || hcnt != (((len / 2) < 1) ? 1 : (len / 2)))) hi_bad++;
        end
    endtask

    task automatic frac_case(input logic [23:0] iv, input logic [7:0] fv, input string req);
        longint t, mn, mx;
        int hb;
        longint b;
        b = base_of(iv);
        set_div(iv, fv);
        collect(256, 1'b1, t, mn, mx, hb);
        check(t == total_of(iv, fv, 256), {req, " R3 total"}, t, total_of(iv, fv, 256));
        check(mn == b && mx == ((fv != 0) ? b + 1 : b), {req, " R4 min/max"}, mn * 1000000 + mx,
              b * 1000000 + ((fv != 0) ? b + 1 : b));
        check(hb == 0, {req, " R9 high time"}, hb, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        longint t, mn, mx;
        int hb, seed_sink, len;
        logic [23:0] ri;
        logic [7:0]  rf;
        seed_sink = $urandom(32'd20240611);
        rst = 1'b1; we = 1'b0; dint = '0; dfrac = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state, pass-through and enable each cycle
        check(en == 1'b1, "R1 enable after reset", en, 1);
        check(clk_out == 1'b0, "R1 clk_o low with clk low", clk_out, 0);
        @(posedge clk); #2;
        check(clk_out == 1'b1, "R1 clk_o high with clk high", clk_out, 1);
        @(negedge clk);
        collect(8, 1'b0, t, mn, mx, hb);
        check(t == 8, "R1 one enable per cycle", t, 8);

        // R2: integer division
        set_div(24'd4, 8'd0);
        collect(8, 1'b1, t, mn, mx, hb);
        check(t == 32 && mn == 4 && mx == 4, "R2 divide by 4", t, 32);
        check(hb == 0, "R9 divide by 4 high time", hb, 0);
        set_div(24'd7, 8'd0);
        collect(6, 1'b1, t, mn, mx, hb);
        check(t == 42 && mn == 7 && mx == 7, "R2 divide by 7", t, 42);
        check(hb == 0, "R9 divide by 7 high time", hb, 0);

        // R3/R4/R9: fractional stepping
        frac_case(24'd5, 8'h40, "frac 5.25");
        frac_case(24'd3, 8'hff, "frac 3.996");

        // R10: integer 1 with fraction
        frac_case(24'd1, 8'h80, "R10 1.5");
        frac_case(24'd1, 8'h01, "R10 1.004");

        // R6: high integer bits ignored
        frac_case(24'hAB0003, 8'h10, "R6 upper bits");

        // R7: write mid-period keeps current length
        set_div(24'd10, 8'd0);
        len = 0;
        repeat (3) begin len++; @(negedge clk); end
        we = 1'b1; dint = 24'd4; dfrac = 8'd0;
        len++; @(negedge clk);
        we = 1'b0;
        while (!en) begin len++; @(negedge clk); end
        check(len == 10, "R7 current period unchanged", len, 10);
        collect(4, 1'b1, t, mn, mx, hb);
        check(t == 16 && mn == 4, "R7 next period uses new value", t, 16);

        // R8: write in the last cycle of a period
        set_div(24'd6, 8'd0);
        repeat (5) @(negedge clk);
        we = 1'b1; dint = 24'd3; dfrac = 8'd0;
        @(negedge clk);
        we = 1'b0;
        check(en == 1'b1, "R8 boundary on schedule", en, 1);
        collect(4, 1'b1, t, mn, mx, hb);
        check(t == 12 && mn == 3 && mx == 3, "R8 next period uses new value", t, 12);

        // Random divisors written at random phases (R3, R4, R9)
        for (int k = 0; k < 6; k++) begin
            ri = 24'(1 + ($urandom % 12));
            rf = 8'($urandom);
            repeat ($urandom % 5) @(negedge clk);
            frac_case(ri, rf, "random");
        end

        // R11: back to exactly 1.0
        set_div(24'd1, 8'd0);
        collect(8, 1'b0, t, mn, mx, hb);
        check(t == 8, "R11 enable every cycle", t, 8);
        @(posedge clk); #2;
        check(clk_out == 1'b1, "R11 clk_o follows clk high", clk_out, 1);
        @(negedge clk);
        check(clk_out == 1'b0, "R11 clk_o follows clk low", clk_out, 0);

        // R5: low integer bits zero (upper bits set as well, R6)
        while (!en) @(negedge clk);
        set_div(24'h050000, 8'd0);
        collect(1, 1'b1, t, mn, mx, hb);
        check(t == 65536, "R5 divide by 65536", t, 65536);
        check(hb == 0, "R9 divide by 65536 high time", hb, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule